// File: doc/BRIEF.md
# Configurable Minimal-Depth Parallel-Prefix Adder

This block is a purely combinational adder for two WIDTH-bit operands and a carry-in. It returns the WIDTH-bit sum and the carry-out. The carry network has exactly log2(WIDTH) levels of (generate, propagate) combine cells. A compile-time fan-out vector chooses which graph of the minimal-depth family is built. A vector of all ones gives the Kogge-Stone graph: every cell drives one lateral wire, and spans overlap. A vector that halves from the top level down gives the Ladner-Fisher graph: at level j one node feeds 2^j cells. Vectors between these two give hybrid graphs that trade wiring against fan-out.

The fan-out vector is written top level first. Entry 0 is the fan-out of the last level (span WIDTH/2), and entry LEVELS-1 is the fan-out of level 0 (span 1). Entries past LEVELS are ignored. An illegal vector, or a WIDTH that is not a power of two, stops elaboration. The same legality function is also available to other code.

Top module: `knowles_adder`

## Requirements
- R1: For every legal fan-out vector, {co_o, sum_o} equals a_i + b_i + c_i as an unsigned (WIDTH+1)-bit value, for all operand values.
- R2: With the all-ones fan-out vector (Kogge-Stone, 32-bit '{1,1,1,1,1}), the result meets R1.
- R3: With the halving fan-out vector (Ladner-Fisher, 32-bit '{16,8,4,2,1}), the result meets R1.
- R4: With the hybrid vectors '{4,4,2,2,1} and '{8,4,4,2,1}, the result meets R1.
- R5: The carry-in enters as a pseudo-bit below bit 0. With a_i = b_i = 0 the result is {0, c_i} (sum bit 0 = c_i). With a_i all ones and b_i = 0, c_i = 1 gives sum 0 and carry-out 1.
- R6: When every bit propagates (b_i = ~a_i), carry-out equals c_i and every sum bit equals ~c_i. The group propagate term of a prefix cell is never set unless the cell's own upper input propagates.
- R7: When every bit generates (a_i = b_i = all ones), carry-out is 1 and the sum is all ones shifted left by one, with c_i in bit 0. A group generate term, once set at a level, stays set at all later levels.
- R8: A fan-out vector is legal only if, at each level j, its entry is a power of two no greater than 2^j and no greater than the entry of level j+1. The package function fanout_legal returns 1 exactly for legal vectors. For 4 bits only '{1,1} and '{2,1} are legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Sum bits |
| co_o | output | 1 | Carry-out |

## Verification
Four 32-bit instances are driven side by side: Kogge-Stone, Ladner-Fisher and two hybrids. They receive a table of operand patterns and a stream of random operands. A wrong source index at any level shows up on some graphs and not on others. All-propagate patterns with each carry-in force the carry to cross every level, so a span or source that stops short shows up as a single wrong high bit. All-generate and carry-in-only patterns tell apart errors in the generate path from errors in the pseudo-bit injection at bit 0. Direct calls to the legality function cover vectors that break the power-of-two, range and ordering rules.

// File: rtl/knowles_pkg.sv
package knowles_pkg;
  localparam int MAX_LVL = 8;

  // entry 0 = fan-out of the top level; entry levels-1 = level 0
  typedef int fo_vec_t [MAX_LVL];

  function automatic bit is_pow2(int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic bit fanout_legal(fo_vec_t v, int levels);
    bit ok;
    ok = (levels > 0) && (levels <= MAX_LVL);
    if (ok) begin
      for (int j = 0; j < levels; j++) begin
        int f;
        f = v[levels-1-j];
        if (!is_pow2(f) || f > (1 << j)) ok = 1'b0;
        if (j < levels - 1) begin
          if (f > v[levels-2-j]) ok = 1'b0;
        end
      end
    end
    return ok;
  endfunction
endpackage

// File: rtl/kpa_bit_terms.sv
module kpa_bit_terms #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] g_o
);
  logic [WIDTH-1:0] g_raw;

  assign p_o   = a_i ^ b_i;
  assign g_raw = a_i & b_i;

  // carry-in pseudo-bit (c_i, c_i) merged into position 0
  always_comb begin
    g_o    = g_raw;
    g_o[0] = g_raw[0] | (p_o[0] & c_i);
  end
endmodule

// File: rtl/kpa_prefix_level.sv
module kpa_prefix_level #(
  parameter int WIDTH = 32,
  parameter int SPAN  = 1,
  parameter int FAN   = 1
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_node
    localparam int SRC = (i / FAN) * FAN - SPAN + FAN - 1;
    if (SRC < 0) begin : g_pass
      assign g_o[i] = g_i[i];
      assign p_o[i] = p_i[i];
    end else begin : g_cell
      // upper span on the left of the combine
      assign g_o[i] = g_i[i] | (p_i[i] & g_i[SRC]);
      assign p_o[i] = p_i[i] & p_i[SRC];

      always_comb begin
        AST_G_KEEP: assert (!g_i[i] || g_o[i]) else $error("generate lost at node %0d", i); // R7
        AST_P_NARROW: assert (!p_o[i] || p_i[i]) else $error("propagate widened at node %0d", i); // R6
      end
    end
  end
endmodule

// File: rtl/kpa_sum_stage.sv
module kpa_sum_stage #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] grp_g_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o
);
  logic [WIDTH-1:0] carry;

  assign carry = {grp_g_i[WIDTH-2:0], c_i};
  assign sum_o = p_i ^ carry;
  assign co_o  = grp_g_i[WIDTH-1];
endmodule

// File: rtl/knowles_adder.sv
module knowles_adder
  import knowles_pkg::*;
#(
  parameter int      WIDTH  = 32,
  parameter fo_vec_t FANOUT = '{16, 8, 4, 2, 1, 0, 0, 0}
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o
);
  localparam int LEVELS = $clog2(WIDTH);

  if (WIDTH < 2 || (1 << LEVELS) != WIDTH) begin : g_bad_width
    $error("WIDTH must be a power of two, at least 2");
  end
  if (!fanout_legal(FANOUT, LEVELS)) begin : g_bad_fanout
    $error("illegal fan-out vector for WIDTH %0d", WIDTH);
  end

  logic [WIDTH-1:0] p_bit;
  logic [WIDTH-1:0] g_lvl [LEVELS+1];
  logic [WIDTH-1:0] p_lvl [LEVELS+1];

  kpa_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .a_i (a_i),
    .b_i (b_i),
    .c_i (c_i),
    .p_o (p_bit),
    .g_o (g_lvl[0])
  );
  assign p_lvl[0] = p_bit;

  for (genvar j = 0; j < LEVELS; j++) begin : g_level
    kpa_prefix_level #(
      .WIDTH (WIDTH),
      .SPAN  (1 << j),
      .FAN   (FANOUT[LEVELS-1-j])
    ) u_level (
      .g_i (g_lvl[j]),
      .p_i (p_lvl[j]),
      .g_o (g_lvl[j+1]),
      .p_o (p_lvl[j+1])
    );
  end

  kpa_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .p_i     (p_bit),
    .grp_g_i (g_lvl[LEVELS]),
    .c_i     (c_i),
    .sum_o   (sum_o),
    .co_o    (co_o)
  );

  always_comb begin
    AST_SUM_EXACT: assert ({co_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_i}))
      else $error("sum mismatch"); // R1
    AST_ALL_PROP: assert (!(&(a_i ^ b_i)) || (co_o == c_i && sum_o == {WIDTH{~c_i}}))
      else $error("propagate chain broken"); // R6
    AST_CIN_ONLY: assert (!(a_i == '0 && b_i == '0) || ({co_o, sum_o} == {{WIDTH{1'b0}}, c_i}))
      else $error("carry-in injection wrong"); // R5
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pchk
    always_comb begin
      AST_PREFIX_P: assert (p_lvl[LEVELS][i] == &p_bit[i:0]) else $error("group propagate %0d", i); // R6
    end
  end
endmodule

// File: tb/tb_knowles_adder.sv
module tb_knowles_adder;
  import knowles_pkg::*;

  localparam int W = 32;
  localparam int NDUT = 4;
  localparam int NRAND = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b;
  logic         ci;
  logic [W-1:0] s  [NDUT];
  logic         co [NDUT];

  int errors = 0;
  int checks = 0;

  // R4 hybrid
  knowles_adder #(.WIDTH(W), .FANOUT('{4, 4, 2, 2, 1, 0, 0, 0})) dut (
    .a_i(a), .b_i(b), .c_i(ci), .sum_o(s[0]), .co_o(co[0]));
  // R2 Kogge-Stone
  knowles_adder #(.WIDTH(W), .FANOUT('{1, 1, 1, 1, 1, 0, 0, 0})) dut_ks (
    .a_i(a), .b_i(b), .c_i(ci), .sum_o(s[1]), .co_o(co[1]));
  // R3 Ladner-Fisher
  knowles_adder #(.WIDTH(W), .FANOUT('{16, 8, 4, 2, 1, 0, 0, 0})) dut_lf (
    .a_i(a), .b_i(b), .c_i(ci), .sum_o(s[2]), .co_o(co[2]));
  // R4 second hybrid
  knowles_adder #(.WIDTH(W), .FANOUT('{8, 4, 4, 2, 1, 0, 0, 0})) dut_h2 (
    .a_i(a), .b_i(b), .c_i(ci), .sum_o(s[3]), .co_o(co[3]));

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'h0000_0001, 32'h0000_0001, 1'b0},
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0},
    '{32'h7FFF_FFFF, 32'h0000_0000, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 1'b0},
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1},
    '{32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1},
    '{32'h0000_FFFF, 32'h0000_0001, 1'b0},
    '{32'h00FF_00FF, 32'h0F0F_0F0F, 1'b1},
    '{32'h1234_5678, 32'h9ABC_DEF0, 1'b0},
    '{32'hFFFF_0000, 32'h0000_FFFF, 1'b0},
    '{32'hDEAD_BEEF, 32'h2152_4110, 1'b1}
  };

  function automatic string dut_name(int k);
    case (k)
      0: return "hybrid-44221 R4";
      1: return "kogge-stone R2";
      2: return "ladner-fisher R3";
      default: return "hybrid-84421 R4";
    endcase
  endfunction

  task automatic check_val(string req, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] ta, logic [W-1:0] tb_, logic tc);
    @(negedge clk);
    a  = ta;
    b  = tb_;
    ci = tc;
    #1;
  endtask

  task automatic check_all(string req, logic [W:0] exp);
    for (int k = 0; k < NDUT; k++)
      check_val($sformatf("%s %s", req, dut_name(k)), {co[k], s[k]}, exp);
  endtask

  function automatic logic [W:0] golden(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check_legal(string req, fo_vec_t v, int lv, bit exp);
    bit got;
    got = fanout_legal(v, lv);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (2) @(posedge clk);

    // idle state: zero in, zero out (R1)
    apply('0, '0, 1'b0);
    check_all("R1 idle", '0);

    // table walk (R1)
    for (int t = 0; t < 12; t++) begin
      apply(TABLE[t].a, TABLE[t].b, TABLE[t].ci);
      check_all("R1 table", golden(TABLE[t].a, TABLE[t].b, TABLE[t].ci));
    end

    // random operands (R1)
    for (int t = 0; t < NRAND; t++) begin
      logic [W-1:0] ra, rb;
      logic rc;
      ra = $urandom();
      rb = $urandom();
      rc = 1'($urandom());
      apply(ra, rb, rc);
      check_all("R1 random", golden(ra, rb, rc));
    end

    // carry-in pseudo-bit (R5)
    apply('0, '0, 1'b1);
    check_all("R5 cin-only", {{W{1'b0}}, 1'b1});
    apply('1, '0, 1'b1);
    check_all("R5 cin-ripple", {1'b1, {W{1'b0}}});

    // all-propagate chains (R6)
    apply(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b0);
    check_all("R6 prop cin0", {1'b0, {W{1'b1}}});
    apply(32'hA5A5_5A5A, 32'h5A5A_A5A5, 1'b1);
    check_all("R6 prop cin1", {1'b1, {W{1'b0}}});
    apply(32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    check_all("R6 prop full", {1'b1, {W{1'b0}}});

    // all-generate (R7)
    apply('1, '1, 1'b0);
    check_all("R7 gen cin0", {1'b1, {(W-1){1'b1}}, 1'b0});
    apply('1, '1, 1'b1);
    check_all("R7 gen cin1", {1'b1, {W{1'b1}}});

    // legality rules (R8)
    check_legal("R8 hybrid 44221", '{4, 4, 2, 2, 1, 0, 0, 0}, 5, 1'b1);
    check_legal("R8 ks 11111", '{1, 1, 1, 1, 1, 0, 0, 0}, 5, 1'b1);
    check_legal("R8 lf 16-8-4-2-1", '{16, 8, 4, 2, 1, 0, 0, 0}, 5, 1'b1);
    check_legal("R8 non-pow2", '{4, 3, 2, 2, 1, 0, 0, 0}, 5, 1'b0);
    check_legal("R8 non-monotonic", '{2, 4, 2, 2, 1, 0, 0, 0}, 5, 1'b0);
    check_legal("R8 exceeds span", '{16, 16, 4, 2, 1, 0, 0, 0}, 5, 1'b0);
    check_legal("R8 4-bit ks", '{1, 1, 0, 0, 0, 0, 0, 0}, 2, 1'b1);
    check_legal("R8 4-bit lf", '{2, 1, 0, 0, 0, 0, 0, 0}, 2, 1'b1);
    check_legal("R8 4-bit bad", '{2, 2, 0, 0, 0, 0, 0, 0}, 2, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule